// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is a target (slave) device on a two-wire serial bus. It holds a small bank of eight byte-wide registers, and one auto-incrementing register pointer selects which register a transfer uses. Both bus lines pass through a two-flop synchroniser and are oversampled by the system clock. START and STOP are detected as SDA edges while SCL is high. The block drives SDA only through an active-high pull-low enable, so the line stays open-drain. A host-side read port gives the rest of the chip a direct view of every register.

In a write transfer, the first data byte after the matched address loads the pointer. Each later byte is stored at the pointer, and the pointer then advances. A read transfer sends the register at the pointer, MSB first, and advances the pointer after each byte. The read goes on while the controller answers ACK and ends on a NACK. The pointer is kept between transfers, so a read with no pointer write before it continues from where the last transfer stopped.

The controlling state machine has the states IDLE, ADDR, ADDR_ACK, WR_BYTE, WR_ACK, RD_BYTE, RD_ACK and IGNORE. A START takes any state to ADDR, and a STOP takes any state to IDLE. On the SCL falling edge that ends the eighth bit, the machine makes one of these moves:
- ADDR goes to ADDR_ACK on an address match and to IGNORE on a mismatch.
- WR_BYTE goes to WR_ACK.
- RD_BYTE goes to RD_ACK.

On the falling edge that ends the acknowledge clock, it makes one of these moves:
- ADDR_ACK goes to WR_BYTE or RD_BYTE, depending on the direction bit.
- WR_ACK goes back to WR_BYTE.
- RD_ACK goes to RD_BYTE when the controller answered ACK and to IGNORE when it answered NACK.

Top module: `i2c_ptr_slave`

## Requirements
- R1: The block acknowledges only the 7-bit address 1101000 (the byte 0xD0 for a write, 0xD1 for a read, direction in bit 0 with 1 meaning read). It acknowledges by pulling SDA low for the whole ninth SCL high phase.
- R2: After any other address, the block leaves SDA released until the next START or STOP, and no register changes.
- R3: The first data byte after a matched write address loads the pointer with that byte modulo 8. The byte is acknowledged and is not stored.
- R4: Each later written byte is acknowledged with a low ninth bit and stored at the pointer. The pointer then advances by one and wraps from 7 to 0.
- R5: After a matched read address, the block sends the register at the pointer MSB first, one bit per SCL pulse. The pointer advances by one after each byte and wraps from 7 to 0.
- R6: The pointer keeps its value across STOP and START, so a read with no pointer write before it continues from the last pointer value.
- R7: A controller ACK (SDA low in the ninth clock) after a read byte makes the block send the next register. A NACK (SDA high) makes it release SDA until the next START or STOP.
- R8: A START or STOP at any point, including in the middle of a byte, clears the bit count. A partial byte has no effect, and a repeated START begins a new address phase.
- R9: After reset all registers read 0 and SDA is released. The host port shows the register selected by its index in the same cycle.
- R10: The block changes its SDA drive only while the synchronised SCL is low. Received bits are taken on SCL rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| host_idx | input | 3 | Register index for the host read port |
| host_data | output | 8 | Contents of the selected register |

## Verification
The assertions check on every cycle that a START always re-arms the address phase with a cleared bit count. They also check that a STOP always leaves the machine idle with SDA released, that the SDA drive never starts while SCL is high, that every register write advances the pointer with wrap, and that every write strobe lands in the bank. Other behaviours only show up over whole bus transactions, so the bench's scenarios must cover them. These are the address filter across all 128 addresses, the pointer load by the first byte, the byte order of reads, the pointer carried from one transfer to the next, the NACK ending a read, and the recovery from a START in the middle of a byte.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } slv_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_prev;
    logic              sda_prev;

    // idle bus level is high on both lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sh   <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh   <= {sda_sh[STAGES-2:0], sda_in};
            scl_prev <= scl_sh[STAGES-1];
            sda_prev <= sda_sh[STAGES-1];
        end
    end

    assign scl_q    = scl_sh[STAGES-1];
    assign sda_q    = sda_sh[STAGES-1];
    assign scl_rise = scl_q & ~scl_prev;
    assign scl_fall = ~scl_q & scl_prev;
    // data edges with the clock held high on both samples
    assign start_ev = scl_q & scl_prev & sda_prev & ~sda_q;
    assign stop_ev  = scl_q & scl_prev & ~sda_prev & sda_q;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int NREG = 8,
    parameter int DW   = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] mem [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    // R4: a write strobe is visible in the bank one cycle later
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
    import i2c_ptr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101000,
    parameter int         NREG     = 8,
    parameter int         SYNC_STG = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_pull_o,
    input  logic [$clog2(NREG)-1:0] host_idx,
    output logic [BYTE_W-1:0]       host_data
);

    localparam int AW    = $clog2(NREG);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    slv_state_e state, nxt;

    logic scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sr, tx_sr, bank_rd;
    logic [AW-1:0]     ptr, ptr_inc;
    logic rw_q, first_q, nack_q, we, byte_end;

    i2c_line_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    assign byte_end = scl_fall && (cnt == FULL) && !start_ev && !stop_ev;
    assign ptr_inc  = (ptr == AW'(NREG - 1)) ? '0 : ptr + 1'b1;
    assign we       = (state == ST_WR_BYTE) && byte_end && !first_q;

    i2c_reg_bank #(.NREG(NREG), .DW(BYTE_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(ptr), .wdata(rx_sr),
        .raddr_a(ptr), .rdata_a(bank_rd),
        .raddr_b(host_idx), .rdata_b(host_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (stop_ev) begin
            nxt = ST_IDLE;
        end else if (start_ev) begin
            nxt = ST_ADDR;
        end else if (scl_fall) begin
            unique case (state)
                ST_ADDR:     if (cnt == FULL)
                                 nxt = (rx_sr[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: nxt = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (cnt == FULL) nxt = ST_WR_ACK;
                ST_WR_ACK:   nxt = ST_WR_BYTE;
                ST_RD_BYTE:  if (cnt == FULL) nxt = ST_RD_ACK;
                ST_RD_ACK:   nxt = nack_q ? ST_IGNORE : ST_RD_BYTE;
                default:     nxt = state;
            endcase
        end
    end

    // bit counting, shifting and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            rw_q    <= 1'b0;
            first_q <= 1'b0;
            nack_q  <= 1'b1;
            ptr     <= '0;
        end else if (start_ev || stop_ev) begin
            cnt     <= '0;
            first_q <= 1'b0;
        end else if (scl_rise) begin
            if (state == ST_ADDR || state == ST_WR_BYTE) begin
                rx_sr <= {rx_sr[BYTE_W-2:0], sda_q};
                cnt   <= cnt + 1'b1;
            end
            if (state == ST_RD_BYTE) cnt <= cnt + 1'b1;
            if (state == ST_RD_ACK) nack_q <= sda_q;
        end else if (scl_fall) begin
            unique case (state)
                ST_ADDR: if (cnt == FULL) begin
                    rw_q <= rx_sr[0];
                    cnt  <= '0;
                end
                ST_ADDR_ACK: begin
                    first_q <= 1'b1;
                    cnt     <= '0;
                    if (rw_q) tx_sr <= bank_rd;
                end
                ST_WR_BYTE: if (cnt == FULL) begin
                    cnt <= '0;
                    if (first_q) begin
                        ptr     <= AW'(rx_sr % NREG);
                        first_q <= 1'b0;
                    end else begin
                        ptr <= ptr_inc;
                    end
                end
                ST_RD_BYTE: begin
                    if (cnt == FULL) begin
                        cnt <= '0;
                        ptr <= ptr_inc;
                    end else begin
                        tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                    end
                end
                ST_RD_ACK: tx_sr <= bank_rd;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_pull_o = 1'b1;
            ST_RD_BYTE:             sda_pull_o = ~tx_sr[BYTE_W-1];
            default:                sda_pull_o = 1'b0;
        endcase
    end

    // R8: a START always re-arms the address phase
    a_r8_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev && !stop_ev |=> (state == ST_ADDR) && (cnt == '0));

    // R8: a STOP always leaves the bus released and idle
    a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE) && !sda_pull_o);

    // R10: drive starts only while the clock is low
    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_q);

    // R4: every stored byte advances the pointer with wrap
    a_r4_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ptr == (($past(ptr) == AW'(NREG - 1)) ? '0 : $past(ptr) + 1'b1));

    // R2: a rejected address never gets an acknowledge
    a_r2_no_ack_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR) && byte_end && (rx_sr[7:1] != DEV_ADDR) |=> !sda_pull_o);

endmodule

// File: tb/sim_i2c_ptr_slave.sv
module sim_i2c_ptr_slave;

    localparam int CLK_P = 10;
    localparam int Q     = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       pull;
    logic [2:0] hidx = '0;
    logic [7:0] hdata;
    wire        sda_bus = m_sda & ~pull;

    int total = 0;
    int bad   = 0;
    int viol  = 0;
    logic [7:0] model [8];
    int mptr = 0;

    always #(CLK_P/2) clk = ~clk;

    i2c_ptr_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_pull_o(pull), .host_idx(hidx), .host_data(hdata)
    );

    // R10 monitor: drive must not change while SCL is high
    logic mon_scl = 1'b1, mon_pull = 1'b0;
    always @(negedge clk) begin
        if (rst_n && m_scl && mon_scl && (pull != mon_pull)) viol++;
        mon_scl  = m_scl;
        mon_pull = pull;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_tx(input logic b, output logic s);
        m_sda = b;
        wait_clk(Q);
        m_scl = 1'b1;
        wait_clk(Q);
        s = sda_bus;
        wait_clk(Q);
        m_scl = 1'b0;
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        wait_clk(Q);
        m_scl = 1'b1;
        wait_clk(Q);
        m_sda = 1'b0;
        wait_clk(Q);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0;
        wait_clk(Q);
        m_scl = 1'b1;
        wait_clk(Q);
        m_sda = 1'b1;
        wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_tx(v[i], s);
        bit_tx(1'b1, ack);
    endtask

    task automatic recv_byte(input logic ack_bit, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_tx(1'b1, s);
            v[i] = s;
        end
        bit_tx(ack_bit, s);
    endtask

    task automatic host_rd(input int idx, output logic [7:0] v);
        hidx = 3'(idx);
        wait_clk(1);
        v = hdata;
    endtask

    task automatic check_bank(input string req);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) begin
            host_rd(i, v);
            check(v == model[i], req, v, model[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic ack;
        logic s;
        logic [7:0] v;
        for (int i = 0; i < 8; i++) model[i] = '0;

        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(5);

        // R9: reset state
        check(pull == 1'b0, "R9 released after reset", pull, 0);
        check_bank("R9 reset contents");

        // R1, R3, R4: pointer 2, eight bytes wrapping through 7 -> 0
        bus_start();
        send_byte(8'hD0, ack);
        check(ack == 1'b0, "R1 write address ack", ack, 0);
        send_byte(8'd2, ack);
        check(ack == 1'b0, "R3 pointer byte ack", ack, 0);
        mptr = 2;
        for (int k = 0; k < 8; k++) begin
            v = 8'((k * 37 + 5) & 255);
            send_byte(v, ack);
            check(ack == 1'b0, "R4 data ack", ack, 0);
            model[mptr] = v;
            mptr = (mptr + 1) % 8;
        end
        bus_stop();
        check_bank("R4 stored bytes");

        // R3: pointer byte is taken modulo 8 and not stored
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'hFA, ack);
        send_byte(8'h11, ack);
        model[2] = 8'h11;
        mptr = 3;
        bus_stop();
        check_bank("R3 pointer modulo");

        // R5, R7, R8: pointer write, repeated start, read wrapping
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'd5, ack);
        bus_start();
        send_byte(8'hD1, ack);
        check(ack == 1'b0, "R1 read address ack", ack, 0);
        mptr = 5;
        for (int k = 0; k < 4; k++) begin
            recv_byte(k == 3, v);
            check(v == model[mptr], "R5 read byte", v, model[mptr]);
            mptr = (mptr + 1) % 8;
        end
        // R7: after NACK the line stays released
        begin
            int lows = 0;
            for (int k = 0; k < 9; k++) begin
                bit_tx(1'b1, s);
                if (!s) lows++;
            end
            check(lows == 0, "R7 released after NACK", lows, 0);
        end
        bus_stop();

        // R6: read with no pointer write continues from pointer 1
        bus_start();
        send_byte(8'hD1, ack);
        recv_byte(1'b1, v);
        check(v == model[mptr], "R6 pointer kept", v, model[mptr]);
        mptr = (mptr + 1) % 8;
        bus_stop();
        bus_start();
        send_byte(8'hD1, ack);
        for (int k = 0; k < 2; k++) begin
            recv_byte(k == 1, v);
            check(v == model[mptr], "R6 R7 continued read", v, model[mptr]);
            mptr = (mptr + 1) % 8;
        end
        bus_stop();

        // R8: START in the middle of a data byte
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'd3, ack);
        for (int i = 0; i < 4; i++) bit_tx(1'b0, s);
        bus_start();
        send_byte(8'hD0, ack);
        check(ack == 1'b0, "R8 address after abort", ack, 0);
        send_byte(8'd4, ack);
        send_byte(8'h5A, ack);
        model[4] = 8'h5A;
        bus_stop();
        check_bank("R8 abort has no effect");

        // R2: sweep every other address
        for (int a = 0; a < 128; a++) begin
            if (a != 7'h68) begin
                bus_start();
                send_byte({7'(a), 1'b0}, ack);
                check(ack == 1'b1, "R2 no address ack", ack, 1);
                send_byte(8'hC3, ack);
                check(ack == 1'b1, "R2 no data ack", ack, 1);
                bus_stop();
            end
        end
        check_bank("R2 bank unchanged");

        check(viol == 0, "R10 drive only while SCL low", viol, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule